// File: doc/BRIEF.md
# Watchdog Timer with Warning Watermark

This block is a single-channel watchdog. A 32-bit count register counts down at a rate set by a 10-bit divider. Software programs the divider ratio, a start value and a warning threshold through a simple synchronous register port, and then sets the run bit. If software stops reloading the count, the count runs out. The block then raises a timeout interrupt, a reset request, or both, depending on which enable bits are set.

An earlier warning interrupt fires when the count equals the programmed threshold. This gives software notice before the timeout. A debug-hold input freezes the countdown while a debugger has the processor stopped. The count can be read back at any time.

All three outputs are sticky, registered levels. They drop when the start value is rewritten or when the run bit is cleared. The divider ratio is captured only when the start value is written, so the ratio should be programmed first.

Top module: `wdog_top`

## Requirements
- R1: After reset, every register reads as zero and all three outputs are low. Register addresses: 0 control, 1 divider ratio, 2 start value, 3 current count, 4 warning threshold.
- R2: Writing the start value (address 2) copies it into the count at once. The count reads it back on the next read. Address 2 also reads back the written value. Writes to the count address (3) are ignored.
- R3: With divider ratio P and start value N, the timeout is reached after (P+1)*(N+1) cycles in which counting is allowed. The timeout interrupt is high on the following clock edge.
- R4: The divider ratio is captured only by a write to the start value. A later write to the divider changes the period only after the next start-value write. The divider register itself reads back its newest value.
- R5: Once the timeout is reached, the count stays at zero and does not wrap.
- R6: Control bit 0 enables counting. The timeout interrupt is raised only if control bit 1 is set. The reset request is raised only if control bit 3 is set.
- R7: The warning interrupt rises one cycle after the count equals the threshold while control bits 0 and 2 are both set. With bit 2 clear, no warning rises.
- R8: While the debug-hold input is high, neither the count nor the divider advances. Each held cycle delays the timeout by exactly one cycle.
- R9: Clearing control bit 0 freezes both the count and the divider phase. Setting bit 0 again resumes from the exact point where counting stopped.
- R10: All three outputs stay high until a start-value write or a control write with bit 0 clear. Either of these drops all three outputs on that clock edge.
- R11: Suppose the run bit is set with the interrupt and reset enables while the count and divider are still zero from reset. The warning then rises after one cycle, and the timeout interrupt and reset request rise after two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears one cycle later |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| dbg_hold | input | 1 | Debug hold; freezes counting while high |
| irq_timeout | output | 1 | Sticky timeout interrupt |
| irq_warn | output | 1 | Sticky warning interrupt |
| rst_req | output | 1 | Sticky reset request |

## Verification
A wrong divider phase or a wrongly captured ratio shows up as a timeout or warning edge that is off by at least one cycle. So the bench compares the exact cycle of every rising output edge, not just the final level. A count that moves during debug hold or while stopped shifts the timeout by as many cycles as it slipped. It also shows at once in a count read taken inside the frozen window. A bad clear or gating path shows within one cycle, as an output that stays high after a clearing write or rises without its enable bit.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL   = 3'd0,
    A_DIV    = 3'd1,
    A_RELOAD = 3'd2,
    A_COUNT  = 3'd3,
    A_MARK   = 3'd4
  } reg_addr_e;

  // bit 0 run, bit 1 timeout irq enable, bit 2 warning enable, bit 3 reset enable
  typedef struct packed {
    logic rst_en;
    logic warn_en;
    logic irq_en;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [REG_AW-1:0]   addr,
  input  logic [CNT_W-1:0]    wdata,
  input  logic [CNT_W-1:0]    count_i,
  output logic [CNT_W-1:0]    rdata,
  output ctrl_t               ctrl_o,
  output logic [DIV_W-1:0]    div_o,
  output logic [CNT_W-1:0]    mark_o,
  output logic                load_stb,
  output logic [CNT_W-1:0]    load_val,
  output logic                clr_stb
);

  ctrl_t             ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  reload_q;
  logic [CNT_W-1:0]  mark_q;
  logic [CNT_W-1:0]  rd_next;
  reg_addr_e         sel;

  assign sel = reg_addr_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      div_q    <= '0;
      reload_q <= '0;
      mark_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        A_CTRL:   ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
        A_DIV:    div_q    <= wdata[DIV_W-1:0];
        A_RELOAD: reload_q <= wdata;
        A_MARK:   mark_q   <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      A_CTRL:   rd_next = CNT_W'(ctrl_q);
      A_DIV:    rd_next = CNT_W'(div_q);
      A_RELOAD: rd_next = reload_q;
      A_COUNT:  rd_next = count_i;
      A_MARK:   rd_next = mark_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  assign ctrl_o   = ctrl_q;
  assign div_o    = div_q;
  assign mark_o   = mark_q;
  assign load_stb = wr_en && (sel == A_RELOAD);
  assign load_val = wdata;
  assign clr_stb  = wr_en && (sel == A_CTRL) && !wdata[0];

  // Read data follows the addressed register one cycle later (R2)
  assert_rd_reload_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == A_RELOAD && !wr_en) |=> rdata == $past(reload_q));

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] ratio_i,
  input  logic             run,
  output logic             tick
);

  logic [DIV_W-1:0] ratio_q;
  logic [DIV_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= '0;
      phase_q <= '0;
    end else if (restart) begin
      ratio_q <= ratio_i;
      phase_q <= '0;
    end else if (run) begin
      if (phase_q == ratio_q) phase_q <= '0;
      else                    phase_q <= phase_q + 1'b1;
    end
  end

  assign tick = run && !restart && (phase_q == ratio_q);

  // Ratio captured only on restart (R4)
  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase_q == '0) && (ratio_q == $past(ratio_i)));
  assert_ratio_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !restart |=> $stable(ratio_q));
  // Divider phase frozen when not running (R8, R9)
  assert_phase_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(phase_q));

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] count_o,
  output logic             expired_o
);

  logic [CNT_W-1:0] count_q;
  logic             exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      exp_q   <= 1'b0;
    end else if (load) begin
      count_q <= load_val;
      exp_q   <= 1'b0;
    end else begin
      if (clr) exp_q <= 1'b0;
      if (tick) begin
        if (count_q == '0) begin
          if (!clr) exp_q <= 1'b1;
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
    end
  end

  assign count_o   = count_q;
  assign expired_o = exp_q;

  assert_load_copy_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> count_q == $past(load_val));
  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && count_q != '0) |=> count_q == $past(count_q) - 1'b1);
  assert_hold_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (exp_q && !load) |=> $stable(count_q));
  assert_stay_expired_R5: assert property (@(posedge clk) disable iff (rst)
    (exp_q && !load && !clr) |=> exp_q);

endmodule

// File: rtl/wdog_alarms.sv
module wdog_alarms
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] mark,
  input  logic             expired,
  input  logic             load,
  input  logic             clr,
  output logic             irq_timeout,
  output logic             irq_warn,
  output logic             rst_req
);

  logic flush;
  logic hit;

  assign flush = load || clr;
  assign hit   = ctrl.run && ctrl.warn_en && (count == mark);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      irq_timeout <= 1'b0;
      irq_warn    <= 1'b0;
      rst_req     <= 1'b0;
    end else begin
      irq_timeout <= expired && ctrl.irq_en;
      rst_req     <= expired && ctrl.rst_en;
      irq_warn    <= irq_warn || hit;
    end
  end

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !ctrl.irq_en |=> !irq_timeout);
  assert_rst_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !ctrl.rst_en |=> !rst_req);
  assert_warn_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.warn_en && !irq_warn) |=> !irq_warn);
  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> !irq_timeout && !irq_warn && !rst_req);

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [CNT_W-1:0]    reg_wdata,
  output logic [CNT_W-1:0]    reg_rdata,
  input  logic                dbg_hold,
  output logic                irq_timeout,
  output logic                irq_warn,
  output logic                rst_req
);

  ctrl_t            ctrl;
  logic [DIV_W-1:0] div_ratio;
  logic [CNT_W-1:0] mark;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] load_val;
  logic             load_stb;
  logic             clr_stb;
  logic             expired;
  logic             active;
  logic             tick;

  wdog_regfile #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr),
    .rd_en    (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .count_i  (count),
    .rdata    (reg_rdata),
    .ctrl_o   (ctrl),
    .div_o    (div_ratio),
    .mark_o   (mark),
    .load_stb (load_stb),
    .load_val (load_val),
    .clr_stb  (clr_stb)
  );

  assign active = ctrl.run && !dbg_hold && !expired;

  wdog_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (load_stb),
    .ratio_i (div_ratio),
    .run     (active),
    .tick    (tick)
  );

  wdog_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (load_stb),
    .load_val  (load_val),
    .clr       (clr_stb),
    .tick      (tick),
    .count_o   (count),
    .expired_o (expired)
  );

  wdog_alarms #(.CNT_W(CNT_W)) u_alarm (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .count       (count),
    .mark        (mark),
    .expired     (expired),
    .load        (load_stb),
    .clr         (clr_stb),
    .irq_timeout (irq_timeout),
    .irq_warn    (irq_warn),
    .rst_req     (rst_req)
  );

  // Debug hold or stopped run bit keeps the count still (R8, R9)
  assert_dbg_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    ((dbg_hold || !ctrl.run) && !load_stb) |=> $stable(count));

endmodule

// File: tb/test_wdog_top.sv
module test_wdog_top;

  localparam logic [2:0] AC = 3'd0, AD = 3'd1, AL = 3'd2, AN = 3'd3, AM = 3'd4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dbg_hold = 1'b0;
  logic        irq_timeout, irq_warn, rst_req;

  always #5 clk = ~clk;

  wdog_top i_wdog_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_hold(dbg_hold),
    .irq_timeout(irq_timeout), .irq_warn(irq_warn), .rst_req(rst_req)
  );

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  int          q_to[$];
  int          q_wn[$];
  int          q_rr[$];
  logic [31:0] q_rd[$];
  string       q_rdtag[$];

  logic rd_seen = 1'b0;
  logic p_to = 1'b0, p_wn = 1'b0, p_rr = 1'b0;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rd_seen <= reg_rd;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rise(input string tag, input bit have, input int exp);
    if (!have) begin
      n_chk++;
      n_fail++;
      $display("FAIL %s %s: actual rise at cycle %0d expected none", cur_req, tag, cyc);
    end else begin
      chk({cur_req, " ", tag}, cyc, exp);
    end
  endtask

  // Monitor: pop expected items as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_seen) begin
        if (q_rd.size() > 0) chk(q_rdtag.pop_front(), reg_rdata, q_rd.pop_front());
      end
      if (irq_timeout && !p_to) begin
        if (q_to.size() > 0) rise("irq_timeout cycle", 1'b1, q_to.pop_front());
        else                 rise("irq_timeout cycle", 1'b0, 0);
      end
      if (irq_warn && !p_wn) begin
        if (q_wn.size() > 0) rise("irq_warn cycle", 1'b1, q_wn.pop_front());
        else                 rise("irq_warn cycle", 1'b0, 0);
      end
      if (rst_req && !p_rr) begin
        if (q_rr.size() > 0) rise("rst_req cycle", 1'b1, q_rr.pop_front());
        else                 rise("rst_req cycle", 1'b0, 0);
      end
    end
    p_to <= irq_timeout;
    p_wn <= irq_warn;
    p_rr <= rst_req;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output int c);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    c = cyc + 1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    q_rd.push_back(exp);
    q_rdtag.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic lvl(input string tag, input logic e_to, input logic e_wn, input logic e_rr);
    @(negedge clk);
    chk({tag, " irq_timeout level"}, 32'(irq_timeout), 32'(e_to));
    chk({tag, " irq_warn level"},    32'(irq_warn),    32'(e_wn));
    chk({tag, " rst_req level"},     32'(rst_req),     32'(e_rr));
  endtask

  initial begin
    int c, ce, cd, cr;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    cur_req = "R1";
    rd(AC, 0, "R1 ctrl");
    rd(AD, 0, "R1 divider");
    rd(AL, 0, "R1 start");
    rd(AN, 0, "R1 count");
    rd(AM, 0, "R1 threshold");
    lvl("R1", 0, 0, 0);

    // R11: enable with everything still zero
    cur_req = "R11";
    wr(AC, 32'hF, c);
    q_wn.push_back(c + 1);
    q_to.push_back(c + 2);
    q_rr.push_back(c + 2);
    repeat (4) @(negedge clk);
    lvl("R10 sticky", 1, 1, 1);
    wr(AC, 32'h0, c);
    lvl("R10 run clear", 0, 0, 0);

    // R2: load copies into count, count address write ignored
    cur_req = "R2";
    wr(AL, 123, c);
    rd(AN, 123, "R2 count after load");
    rd(AL, 123, "R2 start readback");
    wr(AN, 55, c);
    rd(AN, 123, "R2 count write ignored");
    wr(AD, 5, c);
    rd(AD, 5, "R4 divider readback");

    // R3 R5 R7: basic timing, warning, hold at zero
    cur_req = "R3 R7";
    wr(AM, 4, c);
    wr(AD, 3, c);
    wr(AL, 10, c);
    wr(AC, 32'h7, ce);
    q_wn.push_back(ce + 6 * 4 + 1);
    q_to.push_back(ce + 11 * 4 + 1);
    repeat (60) @(negedge clk);
    rd(AN, 0, "R5 count at zero");
    repeat (10) @(negedge clk);
    rd(AN, 0, "R5 count stays zero");
    lvl("R10 sticky", 1, 1, 0);
    wr(AL, 200, c);
    lvl("R10 load clear", 0, 0, 0);
    wr(AC, 32'h0, c);

    // R4 R6: ratio captured at load; reset enable only
    cur_req = "R4 R6";
    wr(AD, 1, c);
    wr(AL, 5, c);
    wr(AD, 7, c);
    wr(AC, 32'h9, ce);
    q_rr.push_back(ce + 6 * 2 + 1);
    repeat (30) @(negedge clk);
    lvl("R6 R7 gating", 0, 0, 1);
    rd(AD, 7, "R4 divider newest");
    wr(AC, 32'h0, c);

    // R8: debug hold (ratio 7 captured here)
    cur_req = "R8";
    wr(AL, 3, c);
    wr(AC, 32'h3, ce);
    q_to.push_back(ce + 4 * 8 + 20 + 1);
    repeat (12) @(negedge clk);
    dbg_hold = 1'b1;
    repeat (10) @(negedge clk);
    rd(AN, 2, "R8 count frozen in hold");
    repeat (8) @(negedge clk);
    dbg_hold = 1'b0;
    repeat (40) @(negedge clk);
    lvl("R8", 1, 0, 0);
    wr(AC, 32'h0, c);

    // R9: stop and resume keeps divider phase
    cur_req = "R9";
    wr(AD, 2, c);
    wr(AL, 4, c);
    wr(AC, 32'h3, ce);
    repeat (5) @(negedge clk);
    wr(AC, 32'h0, cd);
    repeat (7) @(negedge clk);
    rd(AN, 32'(4 - (cd - ce) / 3), "R9 count while stopped");
    repeat (3) @(negedge clk);
    wr(AC, 32'h3, cr);
    q_to.push_back(ce + 5 * 3 + (cr - cd) + 1);
    repeat (30) @(negedge clk);
    lvl("R9", 1, 0, 0);
    wr(AC, 32'h0, c);

    // R7: threshold equal to start value, timeout irq disabled
    cur_req = "R7";
    wr(AM, 6, c);
    wr(AD, 0, c);
    wr(AL, 6, c);
    wr(AC, 32'h5, ce);
    q_wn.push_back(ce + 1);
    repeat (15) @(negedge clk);
    lvl("R7 R6", 0, 1, 0);
    wr(AC, 32'h0, c);
    lvl("R10", 0, 0, 0);

    repeat (5) @(negedge clk);
    chk("R3 R7 R6 missing edges", 32'(q_to.size() + q_wn.size() + q_rr.size()), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog %s: actual hung expected done", cur_req);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule